// File: doc/BRIEF.md
# Dual-Rail to Level-Encoded Two-Phase Output Converter

This block sits on the output side of a protocol converter. Its input is a word of four-phase, return-to-zero dual-rail pairs from a local function block. Its output is a word of level-encoded two-phase pairs toward the next node on the global fabric. Each output pair has a data rail and a parity rail. The data rail carries the bit value. The exclusive-or of the two rails carries the phase of the token, so exactly one wire changes per bit per token. The block is modelled on a clock: every rail is sampled at the rising edge.

Each bit is converted as soon as its own pair evaluates. It does not wait for the whole word. The parity of each bit comes from the evaluated value and a held copy of the input token's phase. The held phase is taken from the input only while the whole dual-rail word sits in its spacer (all rails low). A new token whose phase arrives early therefore cannot disturb outputs that still belong to the previous token.

A word-level completion output follows the phase that all bits agree on. It holds whenever the bits disagree. A pair with both rails high is illegal. It sets a sticky error flag and leaves that bit's outputs untouched.

Top module: `ledr_out_conv`

## Requirements
- R1: After reset every data rail and parity rail is 0, the completion phase output is 0, the error flag is 0 and the held phase is even (0).
- R2: Per bit, the pair is read as follows: true high with false low means value 1; false high with true low means value 0. One clock after such a pair is sampled, that bit's data rail shows the value. This happens whatever the other bits of the word are doing.
- R3: While a pair has both rails low, that bit's data rail and parity rail keep their values.
- R4: When a bit is converted, its parity rail is written as (value XOR held phase). Phase 0 (even) gives parity equal to data; phase 1 (odd) gives parity equal to the inverted data.
- R5: The held phase copies the input phase at a clock edge only when every rail of the word is low. If any rail is high, changes on the input phase have no effect on the held phase or on any parity written.
- R6: When (data XOR parity) is 1 for every bit, the completion phase output becomes 1 one clock later. When it is 0 for every bit, the output becomes 0 one clock later. When the bits disagree, the output holds.
- R7: A pair with both rails high sets the error flag one clock later. The flag stays set until reset, and that bit's data and parity rails stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rail_t | input | N | True rails of the dual-rail word |
| rail_f | input | N | False rails of the dual-rail word |
| in_phase | input | 1 | Phase of the current input token (0 even, 1 odd) |
| ledr_data | output | N | Data rails toward the next node |
| ledr_par | output | N | Parity rails toward the next node |
| done_phase | output | 1 | Word completion: phase all bits agree on |
| pair_err | output | 1 | Sticky flag for a pair with both rails high |

## Verification
Two functions can fall on the same edge. The phase-hold register may open, because the word has just returned to spacer. On that same edge the completion merge may still be catching up on the final bit of the previous token. The bench provokes this by flipping the input phase on the very cycle the rails drop to spacer. It also flips the phase while a partly evaluated word is still high. A cycle model in the bench, written from the requirements, judges the parity of the next token and the completion output edge by edge.

// File: rtl/ledr_pkg.sv
package ledr_pkg;

  typedef enum logic [1:0] {
    PAIR_NULL = 2'b00,
    PAIR_ZERO = 2'b01,
    PAIR_ONE  = 2'b10,
    PAIR_BAD  = 2'b11
  } pair_e;

  function automatic pair_e classify(input logic t, input logic f);
    return pair_e'({t, f});
  endfunction

  function automatic logic parity_for(input logic val, input logic phase);
    return val ^ phase;
  endfunction

  function automatic logic phase_of(input logic d, input logic p);
    return d ^ p;
  endfunction

endpackage

// File: rtl/ledr_bit_cell.sv
module ledr_bit_cell
  import ledr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rail_t,
  input  logic rail_f,
  input  logic phase,
  output logic data,
  output logic par,
  output logic bit_phase,
  output logic bit_active,
  output logic bit_bad
);

  pair_e kind;

  always_comb begin
    kind       = classify(rail_t, rail_f);
    bit_active = rail_t | rail_f;
    bit_bad    = (kind == PAIR_BAD);
    bit_phase  = phase_of(data, par);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data <= 1'b0;
      par  <= 1'b0;
    end else begin
      case (kind)
        PAIR_ONE: begin
          data <= 1'b1;
          par  <= parity_for(1'b1, phase);
        end
        PAIR_ZERO: begin
          data <= 1'b0;
          par  <= parity_for(1'b0, phase);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ledr_phase_hold.sv
module ledr_phase_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic word_idle,
  input  logic in_phase,
  output logic held_phase
);

  always_ff @(posedge clk) begin
    if (!rst_n)         held_phase <= 1'b0;
    else if (word_idle) held_phase <= in_phase;
  end

endmodule

// File: rtl/ledr_agree_merge.sv
module ledr_agree_merge #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] bit_phase,
  output logic         all_one,
  output logic         all_zero,
  output logic         merged
);

  always_comb begin
    all_one  = &bit_phase;
    all_zero = ~|bit_phase;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        merged <= 1'b0;
    else if (all_one)  merged <= 1'b1;
    else if (all_zero) merged <= 1'b0;
  end

endmodule

// File: rtl/ledr_out_conv.sv
module ledr_out_conv #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rail_t,
  input  logic [N-1:0] rail_f,
  input  logic         in_phase,
  output logic [N-1:0] ledr_data,
  output logic [N-1:0] ledr_par,
  output logic         done_phase,
  output logic         pair_err
);

  logic [N-1:0] bit_phase;
  logic [N-1:0] bit_active;
  logic [N-1:0] bit_bad;
  logic         word_idle;
  logic         any_bad;
  logic         held_phase;
  logic         agree_one;
  logic         agree_zero;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_bit
      ledr_bit_cell u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .rail_t    (rail_t[gi]),
        .rail_f    (rail_f[gi]),
        .phase     (held_phase),
        .data      (ledr_data[gi]),
        .par       (ledr_par[gi]),
        .bit_phase (bit_phase[gi]),
        .bit_active(bit_active[gi]),
        .bit_bad   (bit_bad[gi])
      );
    end
  endgenerate

  always_comb begin
    word_idle = ~|bit_active;
    any_bad   = |bit_bad;
  end

  ledr_phase_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_idle (word_idle),
    .in_phase  (in_phase),
    .held_phase(held_phase)
  );

  ledr_agree_merge #(.N(N)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_phase(bit_phase),
    .all_one  (agree_one),
    .all_zero (agree_zero),
    .merged   (done_phase)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       pair_err <= 1'b0;
    else if (any_bad) pair_err <= 1'b1;
  end

endmodule

// File: rtl/ledr_out_conv_chk.sv
module ledr_out_conv_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] rail_t,
  input logic [N-1:0] rail_f,
  input logic [N-1:0] ledr_data,
  input logic [N-1:0] ledr_par,
  input logic         done_phase,
  input logic         pair_err,
  input logic         held_phase
);

  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (ledr_data == '0 && ledr_par == '0 && !done_phase && !pair_err && !held_phase));

  assert_phase_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rail_t | rail_f)) |=> $stable(held_phase));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_err |=> pair_err);

  assert_err_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rail_t & rail_f)) |=> pair_err);

  assert_done_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&(ledr_data ^ ledr_par)) |=> done_phase);

  assert_done_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (~|(ledr_data ^ ledr_par)) |=> !done_phase);

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_bitchk
      assert_true_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_t[gi] && !rail_f[gi]) |=> ledr_data[gi]);
      assert_false_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_f[gi] && !rail_t[gi]) |=> !ledr_data[gi]);
      assert_spacer_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rail_t[gi] && !rail_f[gi]) |=> ($stable(ledr_data[gi]) && $stable(ledr_par[gi])));
      assert_parity_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_t[gi] ^ rail_f[gi]) |=> ((ledr_data[gi] ^ ledr_par[gi]) == $past(held_phase)));
      assert_bad_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_t[gi] && rail_f[gi]) |=> ($stable(ledr_data[gi]) && $stable(ledr_par[gi])));
    end
  endgenerate

endmodule

bind ledr_out_conv ledr_out_conv_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rail_t    (rail_t),
  .rail_f    (rail_f),
  .ledr_data (ledr_data),
  .ledr_par  (ledr_par),
  .done_phase(done_phase),
  .pair_err  (pair_err),
  .held_phase(held_phase)
);

// File: tb/tb_ledr_out_conv.sv
module tb_ledr_out_conv;
  localparam int N = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] rail_t, rail_f;
  logic         in_phase;
  logic [N-1:0] ledr_data, ledr_par;
  logic         done_phase, pair_err;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [N-1:0] m_d, m_p;
  logic         m_held, m_done, m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  ledr_out_conv #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .rail_t(rail_t), .rail_f(rail_f),
    .in_phase(in_phase), .ledr_data(ledr_data), .ledr_par(ledr_par),
    .done_phase(done_phase), .pair_err(pair_err)
  );

  function automatic logic enc_par(input logic v, input logic ph);
    return ph ? ~v : v;
  endfunction

  task automatic check1(input string tag, input string what, input logic [N-1:0] act,
                        input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check1(tag, "data", ledr_data, m_d);
    check1(tag, "parity", ledr_par, m_p);
    check1(tag, "done_phase", {{(N-1){1'b0}}, done_phase}, {{(N-1){1'b0}}, m_done});
    check1(tag, "pair_err", {{(N-1){1'b0}}, pair_err}, {{(N-1){1'b0}}, m_err});
  endtask

  // One clock: drive at the falling edge, advance the model at the rising edge,
  // compare at the next falling edge.
  task automatic step(input logic [N-1:0] t, input logic [N-1:0] f, input logic ph,
                      input string tag);
    logic [N-1:0] x;
    rail_t = t; rail_f = f; in_phase = ph;
    @(posedge clk);
    x = m_d ^ m_p;
    if (&x) m_done = 1'b1;
    else if (x == '0) m_done = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (t[i] && !f[i]) begin m_d[i] = 1'b1; m_p[i] = enc_par(1'b1, m_held); end
      else if (f[i] && !t[i]) begin m_d[i] = 1'b0; m_p[i] = enc_par(1'b0, m_held); end
    end
    if ((t | f) == '0) m_held = ph;
    if ((t & f) != '0) m_err = 1'b1;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    logic [N-1:0] vt, vf;
    unused_seed = $urandom(32'h1EDA5);
    rst_n = 1'b0; rail_t = '0; rail_f = '0; in_phase = 1'b0;
    m_d = '0; m_p = '0; m_held = 1'b0; m_done = 1'b0; m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset state");

    // Odd token: phase latched during spacer, then bits evaluate one at a time
    step('0, '0, 1'b1, "R5 latch odd phase in spacer");
    step(8'h01, 8'h00, 1'b1, "R2 R4 bit0 alone converts odd");
    step(8'h01, 8'h02, 1'b0, "R5 phase flip while busy ignored");
    step(8'h05, 8'hF2, 1'b0, "R4 R6 rest of word odd");
    step(8'h05, 8'hFA, 1'b0, "R6 completion odd");
    step(8'h05, 8'hFA, 1'b0, "R6 completion settled");
    // spacer and new phase arriving on the same edge
    step('0, '0, 1'b0, "R3 R5 spacer with phase change same edge");
    step('0, '0, 1'b0, "R3 spacer hold");
    step(8'hFF, 8'h00, 1'b0, "R2 R4 all ones even");
    step('0, '0, 1'b0, "R6 completion even after spacer");
    step(8'h00, 8'hFF, 1'b1, "R4 all zeros even phase held");
    step('0, '0, 1'b1, "R6 R3 spacer");

    // Random legal traffic
    for (int c = 0; c < 600; c++) begin
      int mode;
      mode = int'($urandom % 3);
      vt = '0; vf = '0;
      if (mode != 0) begin
        for (int i = 0; i < N; i++) begin
          int r;
          r = int'($urandom % 4);
          if (r == 1) vt[i] = 1'b1;
          else if (r == 2) vf[i] = 1'b1;
        end
      end
      step(vt, vf, 1'($urandom % 2), "R2 R3 R4 R5 R6 random");
    end

    // Illegal pair
    step('0, '0, 1'b1, "R7 before illegal");
    check1("R7 flag clear before illegal", "pair_err", {{(N-1){1'b0}}, pair_err}, '0);
    step(8'h11, 8'h10, 1'b1, "R7 illegal bit4 outputs kept");
    step('0, '0, 1'b0, "R7 flag sticky");
    step(8'h00, 8'h01, 1'b0, "R7 flag still sticky");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule